// File: doc/BRIEF.md
# Mixed-Width Integer Execute Stage

This stage runs one integer operation per clock. Each source operand and the destination have their own element width, and these widths are given by three width codes. The stage picks the wider of the two source widths as its working width. It widens each source from that source's own width up to the working width, computes the result at the working width, and then fits the result to the destination width. Fitting widens the result when the destination is wider and cuts it down when the destination is narrower.

One opcode bit selects signed or unsigned handling. That choice applies both to how the sources are widened and to how the result is widened. A single output register holds the result, and the output strobe follows the input strobe by one clock. The 64-bit output always carries the fitted result widened across all 64 bits, so a consumer can take any low slice without extra logic.

Top module: `ewalu_stage`

## Requirements
- R1: Width codes are 2 bits: 0 means 8, 1 means 16, 2 means 32 and 3 means 64 bits. The working width is the larger of the two source widths.
- R2: Except for the copy operation, each source is sign-extended (opcode bit 4 = 1) or zero-extended (bit 4 = 0) from its own width up to the working width before use.
- R3: Opcode[3:0] = 0 is a copy. Source A is taken unchanged within the working width, with no extension of A from its own width.
- R4: Codes 1 through 5 compute A+B, A-B, A&B, A|B and A^B, in that order, at the working width.
- R5: Code 6 shifts left and code 7 shifts right. The right shift is arithmetic when signed and logical when unsigned. The shift amount is the low bits of the unextended operand B, masked to log2 of the working width.
- R6: Code 8 gives 1 when A is less than B (signed or unsigned, per bit 4) and 0 otherwise.
- R7: The output is the working-width result extended from the smaller of the working width and the destination width across all 64 bits. The extension is sign or zero according to bit 4.
- R8: Opcode[3:0] codes 9 through 15 give a result of zero.
- R9: out_valid equals in_valid delayed by one clock. A synchronous active-high reset clears out_valid and result.
- R10: While in_valid is low, the result register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request strobe |
| op_a | input | 64 | Source operand A |
| op_b | input | 64 | Source operand B |
| wd_a | input | 2 | Width code of A |
| wd_b | input | 2 | Width code of B |
| wd_dst | input | 2 | Width code of destination |
| opcode | input | 5 | Bit 4 signed select, bits 3:0 operation |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Fitted and extended result |

## Verification
All 64 width-code triples are crossed with every operation code, both signedness settings and four operand pairs. The pairs are chosen so that the bits just above each narrow width differ from the sign bit. This separates extension from the source's own width from extension at a fixed boundary. Shift operands use values past the masked range, which exposes a wrong mask width. Idle stretches with changing inputs and a reset in the middle of traffic separate register hold from pass-through.

// File: rtl/ewalu_pkg.sv
package ewalu_pkg;

    localparam int XLEN    = 64;
    localparam int WCODE_W = 2;
    localparam int OPC_W   = 5;
    localparam int SH_W    = $clog2(XLEN);
    localparam int NSRC    = 2;

    typedef enum logic [WCODE_W-1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } ewidth_e;

    typedef enum logic [3:0] {
        OP_MOV = 4'd0,
        OP_ADD = 4'd1,
        OP_SUB = 4'd2,
        OP_AND = 4'd3,
        OP_OR  = 4'd4,
        OP_XOR = 4'd5,
        OP_SLL = 4'd6,
        OP_SR  = 4'd7,
        OP_LT  = 4'd8
    } alu_op_e;

    typedef struct packed {
        logic    sgn;
        alu_op_e op;
    } op_ctrl_t;

    typedef struct packed {
        ewidth_e src_a;
        ewidth_e src_b;
        ewidth_e dst;
    } width_set_t;

    typedef struct packed {
        ewidth_e         opw;
        ewidth_e         fit;
        logic [SH_W-1:0] sh_mask;
    } width_plan_t;

    function automatic ewidth_e wider(ewidth_e x, ewidth_e y);
        return (x > y) ? x : y;
    endfunction

    function automatic ewidth_e narrower(ewidth_e x, ewidth_e y);
        return (x < y) ? x : y;
    endfunction

    function automatic logic [XLEN-1:0] width_mask(ewidth_e w);
        case (w)
            EW_8:    return {{(XLEN-8){1'b0}},  {8{1'b1}}};
            EW_16:   return {{(XLEN-16){1'b0}}, {16{1'b1}}};
            EW_32:   return {{(XLEN-32){1'b0}}, {32{1'b1}}};
            default: return {XLEN{1'b1}};
        endcase
    endfunction

    function automatic logic [XLEN-1:0] ext_from(logic [XLEN-1:0] v, ewidth_e w, logic sgn);
        case (w)
            EW_8:    return {{(XLEN-8){sgn & v[7]}},   v[7:0]};
            EW_16:   return {{(XLEN-16){sgn & v[15]}}, v[15:0]};
            EW_32:   return {{(XLEN-32){sgn & v[31]}}, v[31:0]};
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/ewalu_width_sel.sv
module ewalu_width_sel
    import ewalu_pkg::*;
(
    input  width_set_t  widths,
    output width_plan_t plan
);
    logic [SH_W:0] bits_m1;
    ewidth_e       opw;

    always_comb begin
        opw          = wider(widths.src_a, widths.src_b);
        bits_m1      = (SH_W+1)'((8 << opw) - 1);
        plan.opw     = opw;
        plan.fit     = narrower(opw, widths.dst);
        plan.sh_mask = bits_m1[SH_W-1:0];
    end
endmodule

// File: rtl/ewalu_src_ext.sv
module ewalu_src_ext
    import ewalu_pkg::*;
(
    input  logic [XLEN-1:0] val,
    input  ewidth_e         own_w,
    input  logic            sgn,
    input  logic            pass,
    output logic [XLEN-1:0] ext
);
    always_comb begin
        if (pass) ext = val;
        else      ext = ext_from(val, own_w, sgn);
    end
endmodule

// File: rtl/ewalu_exec.sv
module ewalu_exec
    import ewalu_pkg::*;
(
    input  op_ctrl_t        ctl,
    input  logic [XLEN-1:0] a_ext,
    input  logic [XLEN-1:0] b_ext,
    input  logic [SH_W-1:0] shamt,
    output logic [XLEN-1:0] raw
);
    logic lt_s;
    logic lt_u;

    always_comb begin
        lt_s = $signed(a_ext) < $signed(b_ext);
        lt_u = a_ext < b_ext;
        case (ctl.op)
            OP_MOV:  raw = a_ext;
            OP_ADD:  raw = a_ext + b_ext;
            OP_SUB:  raw = a_ext - b_ext;
            OP_AND:  raw = a_ext & b_ext;
            OP_OR:   raw = a_ext | b_ext;
            OP_XOR:  raw = a_ext ^ b_ext;
            OP_SLL:  raw = a_ext << shamt;
            OP_SR:   raw = ctl.sgn ? XLEN'($signed(a_ext) >>> shamt) : (a_ext >> shamt);
            OP_LT:   raw = {{(XLEN-1){1'b0}}, ctl.sgn ? lt_s : lt_u};
            default: raw = '0;
        endcase
    end
endmodule

// File: rtl/ewalu_stage.sv
module ewalu_stage
    import ewalu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [63:0]      op_a,
    input  logic [63:0]      op_b,
    input  logic [1:0]       wd_a,
    input  logic [1:0]       wd_b,
    input  logic [1:0]       wd_dst,
    input  logic [4:0]       opcode,
    output logic             out_valid,
    output logic [63:0]      result
);
    op_ctrl_t        ctl;
    width_set_t      widths;
    width_plan_t     plan;
    logic [XLEN-1:0] src_val  [NSRC];
    ewidth_e         src_w    [NSRC];
    logic            src_pass [NSRC];
    logic [XLEN-1:0] src_ext  [NSRC];
    logic [SH_W-1:0] shamt;
    logic [XLEN-1:0] raw;
    logic [XLEN-1:0] fitted;

    always_comb begin
        ctl.sgn       = opcode[OPC_W-1];
        ctl.op        = alu_op_e'(opcode[OPC_W-2:0]);
        widths.src_a  = ewidth_e'(wd_a);
        widths.src_b  = ewidth_e'(wd_b);
        widths.dst    = ewidth_e'(wd_dst);
        src_val[0]    = op_a;
        src_val[1]    = op_b;
        src_w[0]      = widths.src_a;
        src_w[1]      = widths.src_b;
        src_pass[0]   = (ctl.op == OP_MOV);
        src_pass[1]   = 1'b0;
    end

    ewalu_width_sel u_wsel (
        .widths (widths),
        .plan   (plan)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        ewalu_src_ext u_ext (
            .val   (src_val[g]),
            .own_w (src_w[g]),
            .sgn   (ctl.sgn),
            .pass  (src_pass[g]),
            .ext   (src_ext[g])
        );
    end

    assign shamt = op_b[SH_W-1:0] & plan.sh_mask;

    ewalu_exec u_exec (
        .ctl   (ctl),
        .a_ext (src_ext[0]),
        .b_ext (src_ext[1]),
        .shamt (shamt),
        .raw   (raw)
    );

    assign fitted = ext_from(raw, plan.fit, ctl.sgn);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= fitted;
        end
    end
endmodule

// File: rtl/ewalu_chk.sv
module ewalu_chk
    import ewalu_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [1:0]  wd_a,
    input logic [1:0]  wd_b,
    input logic [1:0]  wd_dst,
    input logic [4:0]  opcode,
    input logic        out_valid,
    input logic [63:0] result
);
    ewidth_e fit_in;
    logic    rst_q;

    always_comb fit_in = narrower(wider(ewidth_e'(wd_a), ewidth_e'(wd_b)), ewidth_e'(wd_dst));

    always_ff @(posedge clk) rst_q <= rst;

    always @(posedge clk) begin
        if (rst_q === 1'b1) begin
            assert_reset_clear_R9: assert (!out_valid && result == '0);
        end
    end

    assert_valid_follow_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    assert_zero_ext_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !opcode[4]) |=> ((result & ~width_mask($past(fit_in))) == '0));

    assert_sign_ext_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode[4]) |=> (result == ext_from(result, $past(fit_in), 1'b1)));

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode[3:0] > 4'd8) |=> (result == '0));

    assert_lt_bool_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode[3:0] == 4'd8) |=> (result[63:1] == '0));
endmodule

bind ewalu_stage ewalu_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .wd_a      (wd_a),
    .wd_b      (wd_b),
    .wd_dst    (wd_dst),
    .opcode    (opcode),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/ewalu_stage_tb_top.sv
module ewalu_stage_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [1:0]  wd_a = '0;
    logic [1:0]  wd_b = '0;
    logic [1:0]  wd_dst = '0;
    logic [4:0]  opcode = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int failures = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic [63:0] hold_val = '0;

    always #10 clk = ~clk;

    ewalu_stage dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .wd_a(wd_a), .wd_b(wd_b), .wd_dst(wd_dst),
        .opcode(opcode), .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] fitw(logic [63:0] v, int n, bit s);
        logic [63:0] t;
        if (n >= 64) return v;
        t = v << (64 - n);
        if (s) return $unsigned($signed(t) >>> (64 - n));
        return t >> (64 - n);
    endfunction

    function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
                                          int ca, int cb, int cd, logic [4:0] opc);
        int wa = 8 << ca;
        int wb = 8 << cb;
        int wd = 8 << cd;
        int ow = (wa > wb) ? wa : wb;
        bit s = opc[4];
        int op = int'(opc[3:0]);
        int sh = int'(b[5:0]) & (ow - 1);
        logic [63:0] ae = (op == 0) ? a : fitw(a, wa, s);
        logic [63:0] be = fitw(b, wb, s);
        logic [63:0] r;
        case (op)
            0: r = ae;
            1: r = ae + be;
            2: r = ae - be;
            3: r = ae & be;
            4: r = ae | be;
            5: r = ae ^ be;
            6: r = ae << sh;
            7: r = s ? $unsigned($signed(ae) >>> sh) : (ae >> sh);
            8: r = s ? 64'($signed(ae) < $signed(be)) : 64'(ae < be);
            default: return 64'd0;
        endcase
        return fitw(r, (ow < wd) ? ow : wd, s);
    endfunction

    function automatic string tag_of(logic [4:0] opc);
        case (opc[3:0])
            4'd0:                      return "R3 R1 R7";
            4'd1, 4'd2, 4'd3, 4'd4, 4'd5: return "R4 R1 R2 R7";
            4'd6, 4'd7:                return "R5 R2 R7";
            4'd8:                      return "R6 R2";
            default:                   return "R8";
        endcase
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic check_out();
        if (exp_q.size() > 0) begin
            logic [63:0] e = exp_q.pop_front();
            string t = tag_q.pop_front();
            chk(out_valid === 1'b1, "R9 valid", 64'(out_valid), 64'd1);
            chk(result === e, t, result, e);
            hold_val = e;
        end else begin
            chk(out_valid === 1'b0, "R9 idle valid", 64'(out_valid), 64'd0);
            chk(result === hold_val, "R10 hold", result, hold_val);
        end
    endtask

    task automatic step(bit v, logic [63:0] a, logic [63:0] b,
                        int ca, int cb, int cd, logic [4:0] opc);
        @(negedge clk);
        check_out();
        in_valid = v; op_a = a; op_b = b;
        wd_a = 2'(ca); wd_b = 2'(cb); wd_dst = 2'(cd); opcode = opc;
        if (v) begin
            exp_q.push_back(model(a, b, ca, cb, cd, opc));
            tag_q.push_back(tag_of(opc));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        exp_q.delete(); tag_q.delete();
        @(negedge clk);
        chk(out_valid === 1'b0, "R9 reset valid", 64'(out_valid), 64'd0);
        chk(result === 64'd0, "R9 reset result", result, 64'd0);
        rst = 1'b0;
        hold_val = '0;
    endtask

    logic [63:0] pa [4];
    logic [63:0] pb [4];

    initial begin
        pa[0] = 64'h8000_0000_8000_80F3; pb[0] = 64'h0123_4567_89AB_CD85;
        pa[1] = 64'h7FFF_FFFF_7FFF_7F7F; pb[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        pa[2] = 64'h0000_0000_0000_0000; pb[2] = 64'h0000_0000_0000_0045;
        pa[3] = 64'hDEAD_BEEF_CAFE_F00D; pb[3] = 64'hFFFF_0000_FF00_7F7A;
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R9 initial valid", 64'(out_valid), 64'd0);
        chk(result === 64'd0, "R9 initial result", result, 64'd0);
        rst = 1'b0;
        for (int p = 0; p < 4; p++)
            for (int ca = 0; ca < 4; ca++)
                for (int cb = 0; cb < 4; cb++)
                    for (int cd = 0; cd < 4; cd++)
                        for (int o = 0; o < 11; o++) begin
                            logic [3:0] oc = (o < 9) ? 4'(o) : ((o == 9) ? 4'd9 : 4'd15);
                            step(1'b1, pa[p], pb[p], ca, cb, cd, {1'b0, oc});
                            step(1'b1, pa[p], pb[p], ca, cb, cd, {1'b1, oc});
                        end
        // R10: idle cycles with moving inputs must not disturb the held result
        for (int k = 0; k < 4; k++)
            step(1'b0, pa[k], pb[k], k, 3 - k, k, 5'(k + 1));
        step(1'b1, 64'h0000_0000_0000_00FF, 64'h1, 0, 0, 3, 5'h11);
        step(1'b0, '1, '1, 3, 3, 3, 5'h01);
        step(1'b0, '0, '0, 0, 0, 0, 5'h02);
        // R9: reset during traffic clears the output register
        step(1'b1, pa[3], pb[3], 3, 3, 3, 5'h01);
        do_reset();
        step(1'b0, pa[0], pb[0], 0, 0, 0, 5'h01);
        step(1'b1, pa[1], pb[1], 1, 2, 3, 5'h12);
        step(1'b0, '0, '0, 0, 0, 0, 5'h00);
        step(1'b0, '0, '0, 0, 0, 0, 5'h00);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule